// File: doc/BRIEF.md
# Scrub Error Statistics Counter

This block collects statistics from a memory scrub engine. The engine delivers one result per checked code word. Each result carries the row address it came from, a marker that flags the last code word of the row, and a flag that is set when the code word had an error. The block keeps two statistics. The first is a global error count. A mode input selects whether it counts erroneous code words or rows that hold at least one erroneous code word. The second is a worst-row record: the largest number of failing code words seen in any one row, together with that row's address.

Neither statistic is shown raw. Each has its own 3-bit threshold code, which selects a power-of-four level. A statistic reads as zero until it reaches its level. Above that point it reads as its true value. A synchronous clear input returns every count to zero, and so does the asynchronous reset. The outputs are meant to be mapped into status registers by logic that sits outside this block.

Top module: `scrub_err_stats`

## Requirements
- R1: An active-low reset or a high `clr` sets the global count, the per-row accumulation, the worst-row count and the worst-row address to zero. While `clr` is high, incoming results change nothing.
- R2: With `mode_cw` = 1, every accepted result that has `res_err` = 1 adds one to the global count. The new value shows at the outputs in the cycle after the clock edge that accepted the result.
- R3: With `mode_cw` = 0, the global count grows by exactly one at a result with `res_eor` = 1, and only when some result of that row had `res_err` = 1. This includes the end-of-row result itself. Rows without errors add nothing.
- R4: Threshold codes decode as follows: 0→4, 1→16, 2→64, 3→256, 4→1024, 5→4096. The reserved codes 6 and 7 act as 4096.
- R5: `glob_rpt` equals the global count when that count is at least the level chosen by `glob_thr`, and zero otherwise. A change of `glob_thr` takes effect at once.
- R6: The per-row count adds up the erroneous results of a row, including the end-of-row result. At the end of the row it is compared with the stored maximum. The maximum and its address (`res_row` of the end-of-row result) are replaced only if the new count is strictly greater.
- R7: `worst_cnt_rpt` and `worst_row_rpt` show the stored maximum and its address when that maximum is at least the level chosen by `worst_thr`. Below that level, both outputs read zero.
- R8: The global count and the per-row count saturate at all-ones and never wrap.
- R9: A cycle with `res_valid` = 0 changes no state, whatever the other result inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all statistics |
| mode_cw | input | 1 | 1: count code words, 0: count rows |
| glob_thr | input | 3 | Threshold code for the global count |
| worst_thr | input | 3 | Threshold code for the worst-row count |
| res_valid | input | 1 | A scrub result is present |
| res_row | input | ROW_W | Row address of the result |
| res_eor | input | 1 | Result is the last code word of its row |
| res_err | input | 1 | Code word had an error |
| glob_rpt | output | GLOB_W | Filtered global count |
| worst_cnt_rpt | output | ROWC_W | Filtered worst-row count |
| worst_row_rpt | output | ROW_W | Address of the worst row, filtered |

## Verification
The end-of-row marker and an error flag can arrive on the same result. That one result then has to count toward the row's own total and also close the row for both statistics. The bench provokes this by ending rows on an erroneous code word. It then judges the global count in both modes and the worst-row count against totals that it works out arithmetically. The second collision is a clear that is held high while valid erroneous results keep arriving. The bench checks that every output stays at zero and that the next rows start from an empty state.

// File: rtl/scrub_stats_pkg.sv
package scrub_stats_pkg;

  // Width that holds the largest threshold level (4096).
  localparam int THR_W = 13;

  typedef logic [2:0] thr_code_t;

  // Power-of-four level for a threshold code; reserved codes clamp to the top level.
  function automatic logic [THR_W-1:0] thr_level(input thr_code_t code);
    logic [THR_W-1:0] lvl;
    case (code)
      3'd0:    lvl = THR_W'(4);
      3'd1:    lvl = THR_W'(16);
      3'd2:    lvl = THR_W'(64);
      3'd3:    lvl = THR_W'(256);
      3'd4:    lvl = THR_W'(1024);
      default: lvl = THR_W'(4096);
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/scrub_thr_filter.sv
module scrub_thr_filter
  import scrub_stats_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  thr_code_t    code,
  output logic         pass,
  output logic [W-1:0] gated
);

  localparam int CMP_W = (W > THR_W) ? W : THR_W;

  logic [CMP_W-1:0] val_ext;
  logic [CMP_W-1:0] lvl_ext;

  always_comb begin
    val_ext = CMP_W'(val);
    lvl_ext = CMP_W'(thr_level(code));
    pass    = (val_ext >= lvl_ext);
    gated   = pass ? val : '0;
  end

endmodule

// File: rtl/scrub_glob_cnt.sv
module scrub_glob_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         mode_cw,
  input  logic         valid,
  input  logic         eor,
  input  logic         err,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         row_err_q, row_err_d;
  logic         bump;
  logic         en;

  // next state
  always_comb begin
    cnt_d     = cnt_q;
    row_err_d = row_err_q;
    bump      = 1'b0;
    if (clr) begin
      cnt_d     = '0;
      row_err_d = 1'b0;
    end else if (valid) begin
      if (mode_cw) bump = err;
      else if (eor) bump = row_err_q | err;
      row_err_d = eor ? 1'b0 : (row_err_q | err);
      if (bump && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
    end
  end

  assign en = clr | valid;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      row_err_q <= 1'b0;
    end else if (en) begin
      cnt_q     <= cnt_d;
      row_err_q <= row_err_d;
    end
  end

  assign cnt = cnt_q;

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q)));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cnt_q - $past(cnt_q)) <= W'(1)));

  // R3
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mode_cw && !(valid && eor)) |=> $stable(cnt_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !valid) |=> $stable(cnt_q));

endmodule

// File: rtl/scrub_worst_row.sv
module scrub_worst_row #(
  parameter int CW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          valid,
  input  logic          eor,
  input  logic          err,
  input  logic [AW-1:0] row,
  output logic [CW-1:0] max_cnt,
  output logic [AW-1:0] max_row
);

  logic [CW-1:0] acc_q, acc_d;
  logic [CW-1:0] max_q, max_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] row_sum;
  logic          en;

  // next state
  always_comb begin
    acc_d   = acc_q;
    max_d   = max_q;
    addr_d  = addr_q;
    row_sum = (err && (acc_q != '1)) ? acc_q + 1'b1 : acc_q;
    if (clr) begin
      acc_d  = '0;
      max_d  = '0;
      addr_d = '0;
    end else if (valid) begin
      if (eor) begin
        acc_d = '0;
        if (row_sum > max_q) begin
          max_d  = row_sum;
          addr_d = row;
        end
      end else begin
        acc_d = row_sum;
      end
    end
  end

  assign en = clr | valid;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      max_q  <= '0;
      addr_q <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      max_q  <= max_d;
      addr_q <= addr_d;
    end
  end

  assign max_cnt = max_q;
  assign max_row = addr_q;

  // R6
  max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (max_q >= $past(max_q)));

  // R6
  update_at_eor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(valid && eor)) |=> ($stable(max_q) && $stable(addr_q)));

  // R8
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && valid && !eor) |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/scrub_err_stats.sv
module scrub_err_stats
  import scrub_stats_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int GLOB_W = 16,
  parameter int ROWC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              mode_cw,
  input  logic [2:0]        glob_thr,
  input  logic [2:0]        worst_thr,
  input  logic              res_valid,
  input  logic [ROW_W-1:0]  res_row,
  input  logic              res_eor,
  input  logic              res_err,
  output logic [GLOB_W-1:0] glob_rpt,
  output logic [ROWC_W-1:0] worst_cnt_rpt,
  output logic [ROW_W-1:0]  worst_row_rpt
);

  logic [GLOB_W-1:0] glob_cnt;
  logic [ROWC_W-1:0] worst_cnt;
  logic [ROW_W-1:0]  worst_row;
  logic              glob_pass;
  logic              worst_pass;
  logic [ROWC_W-1:0] worst_gated;

  scrub_glob_cnt #(.W(GLOB_W)) u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .mode_cw (mode_cw),
    .valid   (res_valid),
    .eor     (res_eor),
    .err     (res_err),
    .cnt     (glob_cnt)
  );

  scrub_worst_row #(.CW(ROWC_W), .AW(ROW_W)) u_worst (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .valid   (res_valid),
    .eor     (res_eor),
    .err     (res_err),
    .row     (res_row),
    .max_cnt (worst_cnt),
    .max_row (worst_row)
  );

  scrub_thr_filter #(.W(GLOB_W)) u_glob_flt (
    .val   (glob_cnt),
    .code  (glob_thr),
    .pass  (glob_pass),
    .gated (glob_rpt)
  );

  scrub_thr_filter #(.W(ROWC_W)) u_worst_flt (
    .val   (worst_cnt),
    .code  (worst_thr),
    .pass  (worst_pass),
    .gated (worst_gated)
  );

  always_comb begin
    worst_cnt_rpt = worst_gated;
    worst_row_rpt = worst_pass ? worst_row : '0;
  end

  // R5
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_rpt != '0) |-> (32'(glob_rpt) >= 32'(thr_level(glob_thr))));

  // R7
  worst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (worst_cnt_rpt == '0) |-> (worst_row_rpt == '0));

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((glob_rpt == '0) && (worst_cnt_rpt == '0) && (worst_row_rpt == '0)));

endmodule

// File: tb/scrub_err_stats_test.sv
module scrub_err_stats_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 8;
  localparam int GLOB_W = 13;
  localparam int ROWC_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              clr;
  logic              mode_cw;
  logic [2:0]        glob_thr;
  logic [2:0]        worst_thr;
  logic              res_valid;
  logic [ROW_W-1:0]  res_row;
  logic              res_eor;
  logic              res_err;
  logic [GLOB_W-1:0] glob_rpt;
  logic [ROWC_W-1:0] worst_cnt_rpt;
  logic [ROW_W-1:0]  worst_row_rpt;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scrub_err_stats #(.ROW_W(ROW_W), .GLOB_W(GLOB_W), .ROWC_W(ROWC_W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .mode_cw       (mode_cw),
    .glob_thr      (glob_thr),
    .worst_thr     (worst_thr),
    .res_valid     (res_valid),
    .res_row       (res_row),
    .res_eor       (res_eor),
    .res_err       (res_err),
    .glob_rpt      (glob_rpt),
    .worst_cnt_rpt (worst_cnt_rpt),
    .worst_row_rpt (worst_row_rpt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; the result is visible at the next falling edge.
  task automatic send(input int row, input bit eor, input bit err);
    res_valid = 1'b1;
    res_row   = ROW_W'(row);
    res_eor   = eor;
    res_err   = err;
    @(negedge clk);
    res_valid = 1'b0;
    res_eor   = 1'b0;
    res_err   = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  // A whole row: n_cw code words, the last n_bad of them erroneous.
  task automatic send_row(input int row, input int n_cw, input int n_bad);
    for (int i = 0; i < n_cw; i++)
      send(row, (i == n_cw - 1), (i >= n_cw - n_bad));
  endtask

  function automatic int lvl(input int code);
    return (code >= 5) ? 4096 : (4 << (2 * code));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; mode_cw = 1'b1; glob_thr = 3'd0; worst_thr = 3'd0;
    res_valid = 1'b0; res_row = '0; res_eor = 1'b0; res_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset glob", int'(glob_rpt), 0);
    check("R1 reset worst cnt", int'(worst_cnt_rpt), 0);
    check("R1 reset worst row", int'(worst_row_rpt), 0);

    // R9 idle cycles with error inputs set
    res_valid = 1'b0; res_err = 1'b1; res_eor = 1'b1;
    repeat (10) @(negedge clk);
    res_err = 1'b0; res_eor = 1'b0;
    glob_thr = 3'd0; worst_thr = 3'd0;
    for (int i = 0; i < 4; i++) send(0, 1'b0, 1'b1);
    check("R9 idle glob", int'(glob_rpt), 4);
    send(0, 1'b1, 1'b0);
    check("R9 idle worst", int'(worst_cnt_rpt), 4);

    // R4 R5 R2 threshold sweep over all codes in code-word mode
    mode_cw = 1'b1;
    for (int c = 0; c < 8; c++) begin
      pulse_clr();
      glob_thr = 3'(c);
      for (int i = 0; i < lvl(c) - 1; i++) send(1, 1'b0, 1'b1);
      check("R5 below level", int'(glob_rpt), 0);
      send(1, 1'b0, 1'b1);
      check("R4 at level", int'(glob_rpt), lvl(c));
      glob_thr = 3'd0;
      #1;
      check("R5 live code change", int'(glob_rpt), lvl(c));
    end

    // R3 row mode: each row has 5 code words, 3 erroneous, last one erroneous
    pulse_clr();
    mode_cw = 1'b0; glob_thr = 3'd0;
    send_row(2, 4, 0);
    for (int r = 0; r < 3; r++) send_row(3 + r, 5, 3);
    check("R3 three rows below", int'(glob_rpt), 0);
    send_row(7, 6, 0);
    check("R3 clean row", int'(glob_rpt), 0);
    send_row(8, 5, 1);
    check("R3 eor-only error row", int'(glob_rpt), 4);
    send_row(9, 3, 2);
    check("R3 one per row", int'(glob_rpt), 5);

    // R2 same pattern in code-word mode
    pulse_clr();
    mode_cw = 1'b1;
    for (int r = 0; r < 3; r++) send_row(3 + r, 5, 3);
    check("R2 code words", int'(glob_rpt), 9);

    // R6 R7 worst row tracking
    pulse_clr();
    worst_thr = 3'd0;
    send_row(10, 4, 2);
    check("R7 below cnt", int'(worst_cnt_rpt), 0);
    check("R7 below row", int'(worst_row_rpt), 0);
    send_row(11, 8, 5);
    check("R6 new max cnt", int'(worst_cnt_rpt), 5);
    check("R6 new max row", int'(worst_row_rpt), 11);
    send_row(12, 6, 5);
    check("R6 equal keeps row", int'(worst_row_rpt), 11);
    send_row(13, 9, 7);
    check("R6 larger cnt", int'(worst_cnt_rpt), 7);
    check("R6 larger row", int'(worst_row_rpt), 13);
    send_row(14, 5, 3);
    check("R6 smaller keeps", int'(worst_cnt_rpt), 7);
    worst_thr = 3'd1;
    #1;
    check("R7 raised cnt", int'(worst_cnt_rpt), 0);
    check("R7 raised row", int'(worst_row_rpt), 0);

    // R8 per-row saturation
    send_row(15, 70, 70);
    check("R8 row sat cnt", int'(worst_cnt_rpt), 63);
    check("R8 row sat addr", int'(worst_row_rpt), 15);
    worst_thr = 3'd2;
    #1;
    check("R7 level above max", int'(worst_cnt_rpt), 0);
    worst_thr = 3'd1;

    // R8 global saturation, level 4096 still reached, 4 code words past top
    pulse_clr();
    mode_cw = 1'b1; glob_thr = 3'd0;
    for (int i = 0; i < 8195; i++) send(0, 1'b0, 1'b1);
    check("R8 glob sat", int'(glob_rpt), 8191);

    // R1 clear held with valid results arriving
    clr = 1'b1;
    for (int i = 0; i < 5; i++) send(20, (i == 4), 1'b1);
    check("R1 clr glob", int'(glob_rpt), 0);
    check("R1 clr worst", int'(worst_cnt_rpt), 0);
    clr = 1'b0;
    mode_cw = 1'b0; worst_thr = 3'd0;
    send_row(21, 4, 4);
    check("R1 after clr worst", int'(worst_cnt_rpt), 4);
    check("R1 after clr glob row", int'(glob_rpt), 0);

    // R1 asynchronous reset
    rst_n = 1'b0;
    #1;
    check("R1 async reset", int'(worst_cnt_rpt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule